// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block performs one arithmetic or logic operation per start strobe on a destination and a source operand, at 8-bit or 16-bit width chosen per operation. It supports four operations: plain addition, addition with carry-in, bitwise AND, and a privilege adjust on a 16-bit selector. It also holds a 16-bit status-flags word. Each operation rewrites only the flags it is defined to touch. Every other flag keeps its value.

The flags word has a fixed layout. Some bit positions always read as constants. A decode stage presents the operands, the operation code and the width select together with `start`. One cycle later the result and the updated flags are valid, and `done` pulses for that one cycle. The result and the flags then hold until the next start.

Top module: `alu_flags_unit`

## Requirements
- R1: The flags word uses this layout: carry (CF) at bit 0, parity (PF) at bit 2, auxiliary carry (AF) at bit 4, zero (ZF) at bit 6, sign (SF) at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow (OF) at bit 11. Bit 1 always reads 1, and bits 3 and 5 always read 0. After reset the flags read 16'h0002 and the result reads 0.
- R2: Operation code 0 (add) produces dst+src at the selected width and updates CF, PF, AF, ZF, SF and OF.
- R3: Operation code 1 (add with carry) produces dst+src+1 when CF is 1 on entry, and dst+src otherwise. It updates the same six flags as add.
- R4: Operation code 2 (AND) produces dst&src at the selected width. It clears CF and OF, updates PF, ZF and SF, and leaves AF at its previous value.
- R5: Operation code 3 (privilege adjust) always works on 16 bits and ignores `wide`. If dst[1:0] < src[1:0] as unsigned numbers, the result is dst with bits 1:0 replaced by src[1:0], and ZF is set. Otherwise the result is dst and ZF is cleared. No other flag changes.
- R6: With `wide`=0 the operands are their low bytes. Result bits 15:8 read 0, and CF, OF, SF and ZF refer to the 8-bit result. With `wide`=1 they refer to the 16-bit result.
- R7: Flag meanings for updated flags: CF is the carry out of the top bit. OF is signed overflow of the addition. SF is the top bit of the result. ZF is 1 when the result is zero. PF is 1 when result bits 7:0 hold an even number of ones. AF is the carry out of bit 3.
- R8: Result and flags load on the clock edge that samples `start`=1, so they are visible in the cycle after start. `done` is high for exactly that cycle. Without `start`, changes on the other inputs leave result and flags unchanged.
- R9: Trap, interrupt-enable and direction (bits 8-10), and any flag an operation does not update, keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Performs the presented operation |
| op | input | 2 | 0 add, 1 add with carry, 2 AND, 3 privilege adjust |
| wide | input | 1 | 1 for 16-bit operands, 0 for 8-bit |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand |
| result | output | 16 | Registered result of the last operation |
| flags | output | 16 | Status-flags word |
| done | output | 1 | One-cycle pulse when result and flags are updated |

## Verification
Every result is due exactly one clock edge after the edge that samples `start`. `result`, `flags` and `done` all change together at that edge. The bench drives each operation on a falling edge and samples the outputs on the following falling edge. It then drops `start` and samples once more a cycle later, to confirm that `done` has fallen and that the outputs held. Idle cycles with changing operands and `start` low are checked the same way: the outputs must not change one cycle later.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int FLAGS_W = 16;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADC  = 2'd1,
    OP_AND  = 2'd2,
    OP_PRIV = 2'd3
  } alu_op_e;

  // flag bit positions; a neighbouring decoder reads this layout
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;

  localparam logic [FLAGS_W-1:0] FIXED_ONE  = 16'h0002;
  localparam logic [FLAGS_W-1:0] FIXED_ZERO = 16'h0028;
  localparam logic [FLAGS_W-1:0] FLAGS_RST  = FIXED_ONE;

  localparam logic [FLAGS_W-1:0] M_LOGIC =
    (16'd1 << FB_CF) | (16'd1 << FB_PF) | (16'd1 << FB_ZF) |
    (16'd1 << FB_SF) | (16'd1 << FB_OF);
  localparam logic [FLAGS_W-1:0] M_ARITH = M_LOGIC | (16'd1 << FB_AF);
  localparam logic [FLAGS_W-1:0] M_PRIV  = (16'd1 << FB_ZF);

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic [FLAGS_W-1:0] op_mask(input alu_op_e o);
    case (o)
      OP_ADD, OP_ADC: return M_ARITH;
      OP_AND:         return M_LOGIC;
      default:        return M_PRIV;
    endcase
  endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e              op,
  input  logic                 wide,
  input  logic [W-1:0]         dst,
  input  logic [W-1:0]         src,
  input  logic                 cin,
  output logic [W-1:0]         res,
  output logic [FLAGS_W-1:0]   fval,
  output logic [FLAGS_W-1:0]   fmask,
  output logic                 rpl_raise
);
  localparam int H = W / 2;

  logic [W-1:0] a, b, sum_r, and_r, priv_r;
  logic [W:0]   sum_full;
  logic [4:0]   nib;
  logic         c_in, carry, ovf, top;

  function automatic logic top_bit(input logic [W-1:0] v, input logic w);
    return w ? v[W-1] : v[H-1];
  endfunction

  always_comb begin
    a = wide ? dst : {{(W-H){1'b0}}, dst[H-1:0]};
    b = wide ? src : {{(W-H){1'b0}}, src[H-1:0]};
    c_in = (op == OP_ADC) && cin;
    sum_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c_in};
    nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, c_in};
    sum_r = wide ? sum_full[W-1:0] : {{(W-H){1'b0}}, sum_full[H-1:0]};
    carry = wide ? sum_full[W] : sum_full[H];
    ovf = (top_bit(a, wide) == top_bit(b, wide)) &&
          (top_bit(sum_r, wide) != top_bit(a, wide));
    and_r = a & b;
    rpl_raise = dst[1:0] < src[1:0];
    priv_r = rpl_raise ? {dst[W-1:2], src[1:0]} : dst;
  end

  always_comb begin
    fval  = '0;
    fmask = op_mask(op);
    res   = '0;
    top   = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res = sum_r;
        fval[FB_CF] = carry;
        fval[FB_AF] = nib[4];
        fval[FB_OF] = ovf;
      end
      OP_AND: begin
        res = and_r;
        fval[FB_CF] = 1'b0;
        fval[FB_OF] = 1'b0;
      end
      default: begin
        res = priv_r;
      end
    endcase
    top = top_bit(res, wide);
    fval[FB_SF] = top;
    fval[FB_PF] = even_ones8(res[7:0]);
    fval[FB_ZF] = (op == OP_PRIV) ? rpl_raise : (res == '0);
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FLAGS_W-1:0] fval,
  input  logic [FLAGS_W-1:0] fmask,
  output logic [FLAGS_W-1:0] flags_q
);
  logic [FLAGS_W-1:0] merged;

  always_comb begin
    merged = (flags_q & ~fmask) | (fval & fmask);
    merged = (merged | FIXED_ONE) & ~FIXED_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flags_q <= FLAGS_RST;
    else if (load) flags_q <= merged;
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (flags_q[1] && !flags_q[3] && !flags_q[5])); // R1
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flags_q)); // R8
  AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (((flags_q ^ $past(flags_q)) & ~$past(fmask)) == '0)); // R9

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic         wide,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] src_in,
  output logic [W-1:0] result,
  output logic [15:0]  flags,
  output logic         done
);
  alu_op_e            op_e, op_q;
  logic [W-1:0]       core_res;
  logic [FLAGS_W-1:0] fval, fmask;
  logic               rpl_raise, rpl_q;

  assign op_e = alu_op_e'(op);

  alu_core #(.W(W)) u_core (
    .op(op_e), .wide(wide), .dst(dst_in), .src(src_in),
    .cin(flags[FB_CF]), .res(core_res), .fval(fval), .fmask(fmask),
    .rpl_raise(rpl_raise)
  );

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(start), .fval(fval), .fmask(fmask),
    .flags_q(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      op_q   <= OP_ADD;
      rpl_q  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= core_res;
        op_q   <= op_e;
        rpl_q  <= rpl_raise;
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start)); // R8
  AST_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_AND) |-> (!flags[FB_CF] && !flags[FB_OF])); // R4
  AST_PRIV_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PRIV) |-> (flags[FB_ZF] == rpl_q)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result)); // R8

endmodule

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic        wide;
  logic [15:0] dst_in, src_in;
  logic [15:0] result, flags;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mflags;

  always #5 clk = ~clk;

  alu_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .dst_in(dst_in), .src_in(src_in), .result(result), .flags(flags),
    .done(done)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from the requirements with integer arithmetic
  task automatic model(input int o, input int w, input int d, input int s,
                       input logic [15:0] fin, output logic [15:0] fout,
                       output logic [15:0] r);
    int n, msk, ua, ub, c, tot, sa, sb, st, res;
    fout = fin;
    n = w ? 16 : 8;
    msk = (1 << n) - 1;
    ua = d & msk; ub = s & msk;
    if (o == 3) begin
      if ((d & 3) < (s & 3)) begin res = (d & 'hFFFC) | (s & 3); fout[6] = 1'b1; end
      else begin res = d; fout[6] = 1'b0; end
      r = res[15:0];
      return;
    end
    if (o == 2) begin
      res = ua & ub;
      fout[0] = 1'b0; fout[11] = 1'b0;
    end else begin
      c = (o == 1 && fin[0]) ? 1 : 0;
      tot = ua + ub + c;
      res = tot & msk;
      fout[0] = tot > msk;
      fout[4] = ((ua & 15) + (ub & 15) + c) > 15;
      sa = (ua >= (1 << (n-1))) ? ua - (1 << n) : ua;
      sb = (ub >= (1 << (n-1))) ? ub - (1 << n) : ub;
      st = sa + sb + c;
      fout[11] = (st >= (1 << (n-1))) || (st < -(1 << (n-1)));
    end
    r = res[15:0];
    fout[7] = ((res >> (n-1)) & 1) == 1;
    fout[6] = res == 0;
    fout[2] = ($countones(r[7:0]) % 2) == 0;
  endtask

  task automatic run_op(input string req, input int o, input int w,
                        input logic [15:0] d, input logic [15:0] s);
    logic [15:0] ef, er;
    model(o, w, d, s, mflags, ef, er);
    op = o[1:0]; wide = w[0]; dst_in = d; src_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " result"}, result, er);
    check({req, " flags"}, flags, ef);
    check({req, " R8 done high"}, {15'd0, done}, 16'd1);
    mflags = ef;
    dst_in = ~d; src_in = s ^ 16'h5A5A; op = 2'(o + 1);
    @(negedge clk);
    check({req, " R8 done low"}, {15'd0, done}, 16'd0);
    check({req, " R8 result held"}, result, er);
    check({req, " R9 flags held"}, flags, ef);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; op = 2'd0; wide = 1'b1;
    dst_in = '0; src_in = '0;
    mflags = 16'h0002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", flags, 16'h0002);
    check("R1 reset result", result, 16'h0000);
    check("R8 reset done", {15'd0, done}, 16'd0);

    // directed corners
    run_op("R2 R6 R7 byte wrap", 0, 0, 16'hABFF, 16'h0001); // 00, CF AF ZF PF
    run_op("R3 adc with CF", 1, 1, 16'h0001, 16'h0002);      // CF was 1 -> 0004
    run_op("R2 R7 word ovf", 0, 1, 16'h7FFF, 16'h0001);      // OF SF AF
    run_op("R2 R7 word carry", 0, 1, 16'hFFFF, 16'hFFFF);
    run_op("R3 adc CF in", 1, 0, 16'h00FF, 16'h0000);        // CF=1 -> 00 carry
    run_op("R4 and clears", 2, 1, 16'hF0F0, 16'hFF00);
    run_op("R4 R6 and byte", 2, 0, 16'hFF80, 16'hFFC0);
    run_op("R5 raise", 3, 0, 16'h1234, 16'h0003);
    run_op("R5 no raise", 3, 1, 16'h1237, 16'h0001);
    run_op("R5 equal", 3, 1, 16'hBEE2, 16'h4442);
    run_op("R3 adc no CF", 1, 1, 16'h8000, 16'h8000);

    for (int i = 0; i < 400; i++) begin
      int o, w;
      o = int'($urandom % 4);
      w = int'($urandom % 2);
      run_op(o == 0 ? "R2 R7 rand add" : o == 1 ? "R3 R7 rand adc" :
             o == 2 ? "R4 rand and" : "R5 rand priv",
             o, w, 16'($urandom), 16'($urandom));
    end
    check("R1 R9 control bits untouched", flags & 16'h0728, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule